// File: doc/BRIEF.md
# Regulator Enable Sequencer with Slew-Limited Voltage Target

This block is the digital start-up controller of a buck-boost regulator. It watches an external enable pin and a software enable bit. It waits out a fixed bias-settling delay and then runs a timed soft-start window. After that it declares the output settled. Throughout, it produces a 7-bit target code for the reference DAC. Code n stands for 2.60 V plus n steps of 20 mV, so the codes run from 2.60 V at 0 to 5.14 V at 127.

The target comes from one of two code inputs, chosen by a select pin. The select level is captured when the part is enabled and again when each soft-start begins. That captured level is held until soft-start finishes, and only then does the live pin take over. The code never jumps. It climbs toward its target at one of two upward rates and falls at one of two slower downward rates, all paced by a 1 MHz tick input. When the regulator is not switching and discharge is allowed, the block closes an output discharge path.

Top module: `vreg_seq_top`

## Requirements
- R1: While `en_pin` is low (sampled at a clock edge), from the next edge on `bias_ready`, `sw_en`, `ss_done` and `vcode` are all 0. Raising `en_pin` again restarts the whole sequence.
- R2: `bias_ready` rises on the `BIAS_US`-th `tick_us` pulse counted after `en_pin` went high, and not before.
- R3: `sw_en` is 1 exactly while soft-start or regulation runs. It starts once `bias_ready` is 1 and `reg_en` is 1. It drops when `reg_en` is cleared, and `vcode` then returns to 0 while `bias_ready` stays 1.
- R4: `ss_done` rises on the `SOFT_US`-th tick after `sw_en` rose, and stays 1 while regulation continues.
- R5: Every soft-start ramps `vcode` upward from code 0.
- R6: The target code is `code_hi` when the effective select is 1 and `code_lo` when it is 0.
- R7: The effective select is the `sel_pin` level captured on the enable edge and again on each soft-start entry, held until `ss_done` is 1. From then on it is the live `sel_pin`.
- R8: Below target, each tick raises `vcode` by 1 when `up_fast`=0 and by 2 when `up_fast`=1, and `vcode` never passes the target.
- R9: Above target, `vcode` falls by 1 every 4 ticks when `dn_fast`=0 and every 2 ticks when `dn_fast`=1.
- R10: `dis_on` is 1 exactly when `dis_en` is 1 and `sw_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| en_pin | input | 1 | External enable pin |
| reg_en | input | 1 | Software enable bit |
| sel_pin | input | 1 | Voltage select pin (1 selects code_hi) |
| code_lo | input | 7 | Target code used when select is 0 |
| code_hi | input | 7 | Target code used when select is 1 |
| up_fast | input | 1 | Rising rate: 0 = 1 code/tick, 1 = 2 codes/tick |
| dn_fast | input | 1 | Falling rate: 0 = 1 code/4 ticks, 1 = 1 code/2 ticks |
| dis_en | input | 1 | Allows output discharge while not switching |
| bias_ready | output | 1 | Bias delay elapsed; registers accessible |
| sw_en | output | 1 | Switching enable to the power stage |
| ss_done | output | 1 | Soft-start window finished |
| dis_on | output | 1 | Output discharge path on |
| vcode | output | 7 | Ramping target code to the reference DAC |

## Verification
The bench builds the block with `BIAS_US`=6 and `SOFT_US`=40 instead of the full 100 and 800. That puts the bias boundary, the last-tick edge of soft-start and the hand-over from the captured select to the live pin within a few hundred ticks. The 40-tick window is long enough for a soft-start ramp to settle at a low target while the select pin has already flipped. It can then be shown that the high target takes over only once `ss_done` rises. The default rate parameters are kept, so the clamp at target, the 2-tick and 4-tick downward cadences and a cadence switch in the middle of a descent are all exercised.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_BIAS  = 3'd1,
    ST_READY = 3'd2,
    ST_SOFT  = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_t;

  // Saturating upward move: never goes past the goal.
  function automatic logic [6:0] climb_toward(input logic [6:0] cur,
                                              input logic [6:0] goal,
                                              input logic [6:0] step);
    logic [6:0] gap;
    gap = goal - cur;
    if (gap <= step) return goal;
    return cur + step;
  endfunction

endpackage

// File: rtl/vreg_seq_fsm.sv
module vreg_seq_fsm
  import vreg_seq_pkg::*;
#(
  parameter int BIAS_US = 100,
  parameter int SOFT_US = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic en_pin,
  input  logic reg_en,
  output logic bias_ready,
  output logic sw_en,
  output logic ss_done,
  output logic capture_sel
);

  localparam int MAX_US = (BIAS_US > SOFT_US) ? BIAS_US : SOFT_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam logic [CNT_W-1:0] BIAS_LAST = CNT_W'(BIAS_US - 1);
  localparam logic [CNT_W-1:0] SOFT_LAST = CNT_W'(SOFT_US - 1);

  seq_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_pin) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_BIAS;
          cnt_d   = '0;
        end
        ST_BIAS: begin
          if (tick_us) begin
            if (cnt_q == BIAS_LAST) begin
              state_d = ST_READY;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_READY: begin
          if (reg_en) begin
            state_d = ST_SOFT;
            cnt_d   = '0;
          end
        end
        ST_SOFT: begin
          if (!reg_en) begin
            state_d = ST_READY;
            cnt_d   = '0;
          end else if (tick_us) begin
            if (cnt_q == SOFT_LAST) begin
              state_d = ST_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (!reg_en) state_d = ST_READY;
        end
        default: begin
          state_d = ST_OFF;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign bias_ready  = (state_q == ST_READY) || (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign sw_en       = (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign ss_done     = (state_q == ST_RUN);
  // Pulse on the edge that enters BIAS or SOFT: capture the select level.
  assign capture_sel = ((state_q == ST_OFF) && (state_d == ST_BIAS)) ||
                       ((state_q != ST_SOFT) && (state_d == ST_SOFT));

endmodule

// File: rtl/vreg_seq_sel.sv
module vreg_seq_sel #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_sel,
  input  logic              live_ok,
  input  logic              sel_pin,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  output logic [CODE_W-1:0] target
);

  logic sel_hold_q;
  logic sel_eff;
  logic [CODE_W-1:0] target_d;

  always_ff @(posedge clk) begin
    if (rst)              sel_hold_q <= 1'b0;
    else if (capture_sel) sel_hold_q <= sel_pin;
  end

  assign sel_eff = live_ok ? sel_pin : sel_hold_q;

  for (genvar b = 0; b < CODE_W; b++) begin : g_mux
    assign target_d[b] = sel_eff ? code_hi[b] : code_lo[b];
  end

  always_ff @(posedge clk) begin
    if (rst) target <= '0;
    else     target <= target_d;
  end

endmodule

// File: rtl/vreg_seq_ramp.sv
module vreg_seq_ramp
  import vreg_seq_pkg::*;
#(
  parameter int CODE_W        = 7,
  parameter int UP_SLOW_STEP  = 1,
  parameter int UP_FAST_STEP  = 2,
  parameter int DN_SLOW_TICKS = 4,
  parameter int DN_FAST_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick_us,
  input  logic              up_fast,
  input  logic              dn_fast,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] vcode
);

  localparam int DN_MAX = (DN_SLOW_TICKS > DN_FAST_TICKS) ? DN_SLOW_TICKS : DN_FAST_TICKS;
  localparam int DIV_W  = $clog2(DN_MAX + 1);
  localparam logic [DIV_W-1:0] DN_SLOW_LAST = DIV_W'(DN_SLOW_TICKS - 1);
  localparam logic [DIV_W-1:0] DN_FAST_LAST = DIV_W'(DN_FAST_TICKS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_last;
  logic [CODE_W-1:0] up_step;

  assign div_last = dn_fast ? DN_FAST_LAST : DN_SLOW_LAST;
  assign up_step  = up_fast ? CODE_W'(UP_FAST_STEP) : CODE_W'(UP_SLOW_STEP);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      vcode <= '0;
      div_q <= '0;
    end else if (tick_us) begin
      if (vcode < target) begin
        vcode <= climb_toward(vcode, target, up_step);
        div_q <= '0;
      end else if (vcode > target) begin
        if (div_q >= div_last) begin
          vcode <= vcode - 1'b1;
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        div_q <= '0;
      end
    end
  end

endmodule

// File: rtl/vreg_seq_top.sv
module vreg_seq_top #(
  parameter int BIAS_US       = 100,
  parameter int SOFT_US       = 800,
  parameter int UP_SLOW_STEP  = 1,
  parameter int UP_FAST_STEP  = 2,
  parameter int DN_SLOW_TICKS = 4,
  parameter int DN_FAST_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_us,
  input  logic       en_pin,
  input  logic       reg_en,
  input  logic       sel_pin,
  input  logic [6:0] code_lo,
  input  logic [6:0] code_hi,
  input  logic       up_fast,
  input  logic       dn_fast,
  input  logic       dis_en,
  output logic       bias_ready,
  output logic       sw_en,
  output logic       ss_done,
  output logic       dis_on,
  output logic [6:0] vcode
);

  localparam int CODE_W = 7;

  logic              capture_sel;
  logic [CODE_W-1:0] target_code;

  vreg_seq_fsm #(
    .BIAS_US(BIAS_US),
    .SOFT_US(SOFT_US)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick_us    (tick_us),
    .en_pin     (en_pin),
    .reg_en     (reg_en),
    .bias_ready (bias_ready),
    .sw_en      (sw_en),
    .ss_done    (ss_done),
    .capture_sel(capture_sel)
  );

  vreg_seq_sel #(
    .CODE_W(CODE_W)
  ) u_sel (
    .clk        (clk),
    .rst        (rst),
    .capture_sel(capture_sel),
    .live_ok    (ss_done),
    .sel_pin    (sel_pin),
    .code_lo    (code_lo),
    .code_hi    (code_hi),
    .target     (target_code)
  );

  vreg_seq_ramp #(
    .CODE_W       (CODE_W),
    .UP_SLOW_STEP (UP_SLOW_STEP),
    .UP_FAST_STEP (UP_FAST_STEP),
    .DN_SLOW_TICKS(DN_SLOW_TICKS),
    .DN_FAST_TICKS(DN_FAST_TICKS)
  ) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .active (sw_en),
    .tick_us(tick_us),
    .up_fast(up_fast),
    .dn_fast(dn_fast),
    .target (target_code),
    .vcode  (vcode)
  );

  assign dis_on = dis_en && !sw_en;

endmodule

// File: rtl/vreg_seq_chk.sv
module vreg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_pin,
  input logic       bias_ready,
  input logic       sw_en,
  input logic       ss_done,
  input logic       dis_on,
  input logic [6:0] vcode,
  input logic [6:0] target
);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en_pin |=> (!bias_ready && !sw_en && !ss_done)); // R1

  AST_BIAS_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
    $rose(bias_ready) |-> $past(en_pin)); // R2

  AST_SW_NEEDS_BIAS: assert property (@(posedge clk) disable iff (rst)
    sw_en |-> bias_ready); // R3

  AST_DONE_IN_SW: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> sw_en); // R4

  AST_SOFT_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> (vcode == 7'd0)); // R5

  AST_UP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (sw_en && $past(sw_en) && (vcode > $past(vcode)))
      |-> ((vcode - $past(vcode)) <= 7'd2) && (vcode <= $past(target))); // R8

  AST_DOWN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (sw_en && $past(sw_en) && (vcode < $past(vcode)))
      |-> (($past(vcode) - vcode) == 7'd1)); // R9

  AST_NO_DISCHARGE_WHILE_SW: assert property (@(posedge clk) disable iff (rst)
    sw_en |-> !dis_on); // R10

endmodule

bind vreg_seq_top vreg_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_pin    (en_pin),
  .bias_ready(bias_ready),
  .sw_en     (sw_en),
  .ss_done   (ss_done),
  .dis_on    (dis_on),
  .vcode     (vcode),
  .target    (target_code)
);

// File: tb/vreg_seq_top_tb.sv
module vreg_seq_top_tb;

  localparam int BIAS_US = 6;
  localparam int SOFT_US = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_us = 1'b0;
  logic       en_pin = 1'b0;
  logic       reg_en = 1'b0;
  logic       sel_pin = 1'b0;
  logic [6:0] code_lo = 7'd0;
  logic [6:0] code_hi = 7'd0;
  logic       up_fast = 1'b0;
  logic       dn_fast = 1'b0;
  logic       dis_en = 1'b0;
  logic       bias_ready, sw_en, ss_done, dis_on;
  logic [6:0] vcode;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vreg_seq_top #(.BIAS_US(BIAS_US), .SOFT_US(SOFT_US)) u_dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .en_pin(en_pin), .reg_en(reg_en),
    .sel_pin(sel_pin), .code_lo(code_lo), .code_hi(code_hi), .up_fast(up_fast),
    .dn_fast(dn_fast), .dis_en(dis_en), .bias_ready(bias_ready), .sw_en(sw_en),
    .ss_done(ss_done), .dis_on(dis_on), .vcode(vcode)
  );

  typedef struct {
    string      req;
    logic [10:0] exp;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      check_ev;

  // Monitor: pops expected items and compares against the sampled outputs.
  initial begin
    forever begin
      @(check_ev);
      while (exp_q.size() > 0) begin
        exp_item_t it;
        logic [10:0] act;
        it  = exp_q.pop_front();
        act = {bias_ready, sw_en, ss_done, dis_on, vcode};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual bias/sw/done/dis/code=%b/%b/%b/%b/%0d expected %b/%b/%b/%b/%0d",
                   it.req, act[10], act[9], act[8], act[7], act[6:0],
                   it.exp[10], it.exp[9], it.exp[8], it.exp[7], it.exp[6:0]);
        end
      end
    end
  end

  // Driver side: push expectation, wake the monitor, let it run.
  task automatic expect_out(input string req, input logic b, input logic s,
                            input logic d, input logic dis, input int code);
    exp_item_t it;
    it.req = req;
    it.exp = {b, s, d, dis, 7'(code)};
    exp_q.push_back(it);
    ->check_ev;
    #1;
  endtask

  // Each tick is a single-cycle pulse followed by idle cycles; returns at a negedge.
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(50000 * 5);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    dis_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    expect_out("R1 reset state", 0, 0, 0, 1, 0);

    code_lo = 7'd10; code_hi = 7'd60; sel_pin = 1'b0; reg_en = 1'b1;
    en_pin = 1'b1;
    idle(1);
    ticks(BIAS_US - 1);
    expect_out("R2 bias not before delay, R10 discharge while off", 0, 0, 0, 1, 0);
    ticks(1);
    expect_out("R3 soft-start begins, R10 discharge released", 1, 1, 0, 0, 0);

    sel_pin = 1'b1;
    ticks(5);
    expect_out("R5 ramp from zero, R8 slow rise", 1, 1, 0, 0, 5);
    ticks(10);
    expect_out("R7 select frozen, R8 clamp at low target", 1, 1, 0, 0, 10);
    ticks(SOFT_US - 16);
    expect_out("R4 not done one tick early", 1, 1, 0, 0, 10);
    ticks(1);
    expect_out("R4 done on last tick", 1, 1, 1, 0, 10);
    ticks(1);
    expect_out("R6 R7 live select to high code", 1, 1, 1, 0, 11);
    up_fast = 1'b1;
    ticks(5);
    expect_out("R8 fast rise", 1, 1, 1, 0, 21);
    ticks(20);
    expect_out("R8 clamp at high target", 1, 1, 1, 0, 60);

    sel_pin = 1'b0;
    ticks(3);
    expect_out("R9 slow fall holds for 3 ticks", 1, 1, 1, 0, 60);
    ticks(1);
    expect_out("R9 slow fall steps on 4th tick", 1, 1, 1, 0, 59);
    ticks(8);
    expect_out("R9 slow fall cadence", 1, 1, 1, 0, 57);
    dn_fast = 1'b1;
    ticks(1);
    expect_out("R9 fast fall holds one tick", 1, 1, 1, 0, 57);
    ticks(1);
    expect_out("R9 fast fall steps", 1, 1, 1, 0, 56);

    reg_en = 1'b0;
    idle(3);
    expect_out("R3 register disable, R10 discharge", 1, 0, 0, 1, 0);
    dis_en = 1'b0;
    idle(1);
    expect_out("R10 discharge disabled", 1, 0, 0, 0, 0);

    sel_pin = 1'b1;
    reg_en = 1'b1;
    idle(3);
    ticks(3);
    expect_out("R5 R7 new soft-start captures high select", 1, 1, 0, 0, 6);

    en_pin = 1'b0;
    idle(2);
    expect_out("R1 pin low turns off", 0, 0, 0, 0, 0);
    en_pin = 1'b1;
    idle(1);
    ticks(BIAS_US - 1);
    expect_out("R1 R2 restart waits bias delay", 0, 0, 0, 0, 0);
    ticks(1);
    expect_out("R2 bias ready after restart", 1, 1, 0, 0, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule